// File: doc/BRIEF.md
# Table-Driven SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the peripheral clock. A small rate index selects one divisor from a fixed table whose steps alternate between ratios of 1.5 and 4/3. The table runs 3, 4, 6, 8, 12, 16 and onward up to 1024, so odd and non-power-of-two ratios have to be produced. The block also emits a one-cycle strobe on each serial clock edge, so that an attached shifter knows when to launch and when to sample data.

Each serial clock period opens with the active level (the level opposite to the idle polarity) for floor(N/2) input cycles and closes at the idle level for ceil(N/2) cycles. A new index is picked up only when the current period has finished, so a rate change never shortens or stretches a pulse. Deasserting the enable returns the clock to idle on the next cycle. Choosing the index for a wanted frequency is left to software, and the data shifter is a separate block.

Top module: `spi_table_sclk_div`

## Requirements
- R1: For index i in 1..MAX_IDX the period in input clocks is N = 3·2^((i−1)/2) when i is odd and N = 2^(i/2+1) when i is even (3, 4, 6, 8, 12, ..., 768, 1024).
- R2: Index 0 is reserved: while it is selected, sclk stays at the idle level and neither strobe pulses.
- R3: Index 1 gives N = 3 only while div3_en is 1; with div3_en at 0 it behaves as index 2 (N = 4).
- R4: An index above MAX_IDX (default 18) gives the divisor of MAX_IDX.
- R5: Every period starts with floor(N/2) cycles at the active level followed by ceil(N/2) cycles at the idle level.
- R6: The idle level equals cpol; the active level is its inverse.
- R7: lead_stb is 1 for exactly the first cycle of each active phase and trail_stb for exactly the first cycle of each idle phase; the two are never 1 together.
- R8: A change of rate_idx during a period takes effect at the start of the next period; the running period keeps its length.
- R9: While en is 0 the clock is idle and both strobes are 0 from the first clock edge that samples en low; after en is sampled high with a legal index, the next cycle starts a period with lead_stb.
- R10: While rst_n is 0, sclk is at the idle level and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock generation enable |
| rate_idx | input | IDX_W | Rate index into the divisor table |
| div3_en | input | 1 | Permits the divide-by-3 entry at index 1 |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe with the edge into the active level |
| trail_stb | output | 1 | One-cycle strobe with the edge back to the idle level |

## Verification
The hardest situation to reach is an index change that lands in the middle of a long period, because the old divisor must keep running after the port already shows the new value. The stimulus waits for a leading strobe at divisor 128, changes the index ten cycles later, and then counts the cycles to the next leading strobe and the length of the period after it. The odd divisor 3 with its one-cycle active phase, and the clamped out-of-range index, are each set up from a disabled state so that the first period can be measured from its leading strobe.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Divisor for a table position; 0 marks the reserved entry.
  function automatic int unsigned rate_divisor(input int unsigned idx);
    if (idx == 0)
      return 0;
    else if (idx[0])
      return 32'd3 << ((idx - 1) / 2);
    else
      return 32'd1 << (idx / 2 + 1);
  endfunction

  function automatic int unsigned div_width(input int unsigned max_idx);
    return $clog2(rate_divisor(max_idx) + 1);
  endfunction

endpackage

// File: rtl/spi_rate_lut.sv
module spi_rate_lut
  import spi_sclk_pkg::*;
#(
  parameter int unsigned MAX_IDX = 18,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned DIV_W   = 11
) (
  input  logic [IDX_W-1:0] rate_idx,
  input  logic             div3_en,
  output logic [DIV_W-1:0] div_o,
  output logic             valid_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_IDX);

  logic [DIV_W-1:0] tbl [0:MAX_IDX];
  logic [IDX_W-1:0] idx_clamped;
  logic [IDX_W-1:0] idx_eff;

  for (genvar g = 0; g <= MAX_IDX; g++) begin : g_tbl
    assign tbl[g] = DIV_W'(rate_divisor(g));
  end

  always_comb begin
    idx_clamped = (rate_idx > TOP_IDX) ? TOP_IDX : rate_idx;
    idx_eff     = idx_clamped;
    if (idx_clamped == IDX_W'(1) && !div3_en)
      idx_eff = IDX_W'(2);
  end

  assign div_o   = tbl[idx_eff];
  assign valid_o = (idx_eff != '0);

endmodule

// File: rtl/spi_sclk_phase.sv
module spi_sclk_phase #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_ok_i,
  output logic             act_o,
  output logic             lead_o,
  output logic             trail_o
);

  logic             run_q, run_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             act_q, act_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_nxt;
  logic             at_boundary;

  assign half        = div_q >> 1;
  assign cnt_nxt     = cnt_q + DIV_W'(1);
  assign at_boundary = !run_q || (cnt_nxt == div_q);

  always_comb begin
    run_d   = run_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    act_d   = act_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!en) begin
      run_d = 1'b0;
      cnt_d = '0;
      act_d = 1'b0;
    end else if (at_boundary) begin
      cnt_d = '0;
      if (div_ok_i) begin
        run_d  = 1'b1;
        div_d  = div_i;
        act_d  = 1'b1;
        lead_d = 1'b1;
      end else begin
        run_d = 1'b0;
        act_d = 1'b0;
      end
    end else begin
      cnt_d   = cnt_nxt;
      act_d   = (cnt_nxt < half);
      trail_d = (cnt_nxt == half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      div_q   <= '0;
      act_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      act_q   <= act_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign act_o   = act_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

endmodule

// File: rtl/spi_table_sclk_div.sv
module spi_table_sclk_div
  import spi_sclk_pkg::*;
#(
  parameter int unsigned MAX_IDX = 18,
  parameter int unsigned IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] rate_idx,
  input  logic             div3_en,
  input  logic             cpol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  localparam int unsigned DIV_W = div_width(MAX_IDX);

  logic [DIV_W-1:0] sel_div;
  logic             sel_ok;
  logic             active;

  spi_rate_lut #(
    .MAX_IDX (MAX_IDX),
    .IDX_W   (IDX_W),
    .DIV_W   (DIV_W)
  ) u_lut (
    .rate_idx (rate_idx),
    .div3_en  (div3_en),
    .div_o    (sel_div),
    .valid_o  (sel_ok)
  );

  spi_sclk_phase #(
    .DIV_W (DIV_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .div_i    (sel_div),
    .div_ok_i (sel_ok),
    .act_o    (active),
    .lead_o   (lead_stb),
    .trail_o  (trail_stb)
  );

  assign sclk = active ^ cpol;

endmodule

// File: rtl/spi_table_sclk_div_chk.sv
module spi_table_sclk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);

  // R7: strobes are exclusive
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  // R7: leading strobe comes with the active level
  p_lead_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol));

  // R7: trailing strobe comes with the idle level
  p_trail_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol));

  // R7: a leading strobe lasts one cycle
  p_lead_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  // R9: disabled means idle clock and quiet strobes
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((sclk == cpol) && !lead_stb && !trail_stb));

endmodule

bind spi_table_sclk_div spi_table_sclk_div_chk u_chk (.*);

// File: tb/test_spi_table_sclk_div.sv
`timescale 1ns/1ps
module test_spi_table_sclk_div;

  localparam int MAXI = 18;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] rate_idx;
  logic       div3_en;
  logic       cpol;
  logic       sclk, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_table_sclk_div i_spi_table_sclk_div (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_idx(rate_idx),
    .div3_en(div3_en), .cpol(cpol), .sclk(sclk),
    .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic int ref_div(input int idx, input bit sp);
    int v;
    if (idx == 0) return 0;
    if (idx > MAXI) idx = MAXI;
    if (idx == 1 && !sp) idx = 2;
    v = 3;
    for (int k = 2; k <= idx; k++)
      v = (k % 2 == 0) ? (v * 4) / 3 : (v * 3) / 2;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: position within a period, -1 when stopped
  int m_pos, m_div;
  bit m_act, m_lead, m_trail;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = -1; m_div = 0; m_act = 0; m_lead = 0; m_trail = 0;
    end else if (!en) begin
      m_pos = -1; m_act = 0; m_lead = 0; m_trail = 0;
    end else if (m_pos < 0 || m_pos == m_div - 1) begin
      int d;
      d = ref_div(int'(rate_idx), div3_en);
      m_trail = 0;
      if (d == 0) begin
        m_pos = -1; m_act = 0; m_lead = 0;
      end else begin
        m_div = d; m_pos = 0; m_act = 1; m_lead = 1;
      end
    end else begin
      m_pos++;
      m_lead  = 0;
      m_act   = (m_pos < m_div / 2);
      m_trail = (m_pos == m_div / 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(sclk === (m_act ^ cpol), "R5 sclk level", int'(sclk), int'(m_act ^ cpol));
      check(lead_stb === m_lead, "R7 lead_stb", int'(lead_stb), int'(m_lead));
      check(trail_stb === m_trail, "R7 trail_stb", int'(trail_stb), int'(m_trail));
    end
  end

  task automatic drive_step();
    @(negedge clk); #1;
  endtask

  task automatic wait_lead();
    int n = 0;
    while (lead_stb !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
  endtask

  // Start cleanly from disabled, then measure one full period
  task automatic measure(input int idx, input bit sp, input int expd, input string req);
    int n = 0, hi = 0;
    en = 0; rate_idx = 5'(idx); div3_en = sp;
    drive_step(); drive_step();
    en = 1;
    @(negedge clk);
    wait_lead();
    do begin
      if (sclk !== cpol) hi++;
      n++;
      @(negedge clk);
    end while (lead_stb !== 1'b1 && n < 5000);
    check(n == expd, {req, " period"}, n, expd);
    check(hi == expd / 2, "R5 active length", hi, expd / 2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; en = 1; rate_idx = 5'd2; div3_en = 0; cpol = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(sclk === 1'b0 && lead_stb === 1'b0 && trail_stb === 1'b0, "R10 reset cpol0",
          int'({sclk, lead_stb, trail_stb}), 0);
    cpol = 1; #1;
    check(sclk === 1'b1, "R10 reset idle high", int'(sclk), 1);
    cpol = 0; en = 0;
    drive_step();
    rst_n = 1;
    drive_step();

    // R1 table entries
    measure(2, 0, ref_div(2, 0), "R1 idx2");
    check(ref_div(2, 0) == 4, "R1 table", ref_div(2, 0), 4);
    measure(3, 0, 6, "R1 idx3");
    measure(5, 0, 12, "R1 idx5");
    measure(12, 0, 128, "R1 idx12");
    measure(18, 0, 1024, "R1 idx18");
    // R3 divide by three gated
    measure(1, 1, 3, "R3 idx1 special");
    measure(1, 0, 4, "R3 idx1 plain");
    // R4 clamp
    measure(25, 0, 1024, "R4 clamp");
    // R6 inverted polarity
    cpol = 1;
    measure(7, 0, 24, "R6 cpol1");
    en = 0; drive_step(); drive_step();
    check(sclk === 1'b1, "R6 idle high", int'(sclk), 1);
    cpol = 0; drive_step();

    // R2 reserved index
    rate_idx = 0; en = 1; n = 0;
    repeat (60) begin
      @(negedge clk);
      if (lead_stb === 1'b1 || trail_stb === 1'b1 || sclk !== cpol) n++;
    end
    check(n == 0, "R2 index0 quiet", n, 0);

    // R8 change mid-period
    en = 0; rate_idx = 5'd12; drive_step(); drive_step();
    en = 1;
    @(negedge clk);
    wait_lead();
    repeat (10) @(negedge clk);
    #1 rate_idx = 5'd2;
    n = 10;
    @(negedge clk);
    while (lead_stb !== 1'b1 && n < 5000) begin n++; @(negedge clk); end
    check(n == 127, "R8 old period kept", n + 1, 128);
    n = 0;
    do begin n++; @(negedge clk); end while (lead_stb !== 1'b1 && n < 5000);
    check(n == 4, "R8 new period", n, 4);

    // R9 disable mid active phase, then restart
    rate_idx = 5'd6; drive_step();
    wait_lead();
    #1 en = 0;
    @(negedge clk);
    check(sclk === cpol && lead_stb === 1'b0 && trail_stb === 1'b0, "R9 stop",
          int'({sclk, lead_stb, trail_stb}), int'({cpol, 2'b00}));
    #1 en = 1;
    @(negedge clk);
    check(lead_stb === 1'b1 && sclk === ~cpol, "R9 restart", int'(lead_stb), 1);

    repeat (20) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule